// File: doc/BRIEF.md
# USB Device Run-Control Register Sequencer

This block is the 32-bit memory-mapped run-control word of a USB device controller, together with the sequencing logic that turns software writes into requests towards the controller core. Software starts and stops the controller through a run bit. The block then runs the stop sequence: it asks the core to disconnect, waits for the disconnect to finish and for the core to go idle, and only then raises a halted flag. A keep-connect bit changes that sequence. With it set, a stop raises no disconnect request, and a host resume from deep suspend is held as a pending flag instead of letting the core return to the active state on its own.

The same word carries a save command with a busy flag, a restore command, a 4-bit link-state request, a self-clearing soft reset and a set of plain threshold and enable fields. The save, restore and soft-reset bits act as one-cycle commands and read back as zero. A link-state request reaches the core only when the written code differs from the code last held, so software must write zero between two identical requests. Core-side events arrive as one-cycle input strobes, except for core idle, which is a level.

Top module: `usb_run_ctrl`

## Requirements
- R1: A write with bit 31 set moves the controller to running. From the cycle after the write, runActive is 1, halted is 0 and bit 31 reads back 1.
- R2: With bit 19 written 0, a write clearing bit 31 while running gives a one-cycle discReq in the cycle after the write. halted rises only after discDone has been seen and coreIdle is high, one cycle after both hold.
- R3: With bit 19 written 1 in the stopping write, no discReq is produced. halted rises one cycle after coreIdle is high, with no discDone needed.
- R4: A write with bit 16 set while saveBusy is 0 sets saveBusy and gives a one-cycle saveReq, both in the cycle after the write. saveBusy clears in the cycle after a saveDone strobe. A save write while saveBusy is 1 gives no saveReq.
- R5: A write with bit 17 set gives a one-cycle restoreReq in the cycle after the write. Bits 17 and 16 read back 0.
- R6: A write with a nonzero code in bits 8:5 that differs from the held code gives a one-cycle linkReqValid with that code on linkReqCode. Writing the same code again gives nothing. Writing 0 gives nothing but re-arms the same code. Bits 8:5 read back 0.
- R7: A suspExit strobe clears the held link code, so the same code written next is issued again.
- R8: After reset, rdData reads 0x00F00000. Bits 30, 29, 17, 16, 15:13, 8:5 and 4:0 always read 0. halted is 1 and saveBusy is 0.
- R9: A write with bit 30 set raises coreRst for exactly one cycle and applies no other field of that write. In the cycle after, every field and status is back at its reset value.
- R10: A hostResumeReq strobe with bit 19 held at 1 sets resumePending and gives no autoResume. With bit 19 at 0 it gives a one-cycle autoResume. resumePending clears when a link request is issued.
- R11: Bits 28:24, 23:20, 19, 18 and 12:9 are plain read/write fields that read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 32 | Register write data |
| rdData | output | 32 | Register read value |
| coreIdle | input | 1 | Core idle level |
| discDone | input | 1 | Disconnect finished strobe |
| saveDone | input | 1 | Save finished strobe |
| suspExit | input | 1 | Link left suspend strobe |
| hostResumeReq | input | 1 | Host resume from deep suspend strobe |
| runActive | output | 1 | Controller running |
| halted | output | 1 | Controller halted status |
| discReq | output | 1 | Disconnect request pulse |
| saveReq | output | 1 | Save request pulse |
| saveBusy | output | 1 | Save in progress status |
| restoreReq | output | 1 | Restore request pulse |
| linkReqValid | output | 1 | Link-state request pulse |
| linkReqCode | output | 4 | Link-state request code |
| resumePending | output | 1 | Resume held for software |
| autoResume | output | 1 | Core may resume on its own, pulse |
| coreRst | output | 1 | Internal soft reset pulse |

## Verification
A saveDone strobe from the core and a save write from software can land in the same cycle while saveBusy is set. The bench provokes this by driving both inputs in one cycle. It expects saveBusy to fall and no saveReq to appear, because the write was made while the block was busy. A save write in the next cycle must then be accepted with a fresh saveReq, which shows that the busy flag cleared and that the dropped write left nothing behind.

// File: rtl/runctl_pkg.sv
package runctl_pkg;
  localparam int REG_W     = 32;
  localparam int LINK_W    = 4;
  localparam int IDLE_W    = 5;
  localparam int NYET_W    = 4;
  localparam int PMEN_W    = 4;

  localparam int B_RUN     = 31;
  localparam int B_SRST    = 30;
  localparam int B_IDLE_LO = 24;
  localparam int B_NYET_LO = 20;
  localparam int B_KEEP    = 19;
  localparam int B_L1HIB   = 18;
  localparam int B_RESTORE = 17;
  localparam int B_SAVE    = 16;
  localparam int B_PMEN_LO = 9;
  localparam int B_LINK_LO = 5;

  localparam logic [NYET_W-1:0] NYET_RST = '1;

  typedef enum logic [1:0] {ST_HALT, ST_RUN, ST_STOP} runSt_t;

  typedef struct packed {
    logic runWr;
    logic runVal;
    logic keepVal;
    logic saveWr;
    logic restoreWr;
  } swCmd_t;
endpackage

// File: rtl/runctl_datapath.sv
module runctl_datapath
  import runctl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              clrSync,
  input  logic              wrEn,
  input  logic [REG_W-1:0]  wrData,
  input  logic              suspExit,
  input  logic              runBit,
  output swCmd_t            cmd,
  output logic              softRstReq,
  output logic              keepConn,
  output logic              linkFire,
  output logic              linkReqValid,
  output logic [LINK_W-1:0] linkReqCode,
  output logic [REG_W-1:0]  rdData
);
  logic [IDLE_W-1:0] idleThr;
  logic [NYET_W-1:0] nyetThr;
  logic              l1Hib;
  logic [PMEN_W-1:0] pmEn;
  logic [LINK_W-1:0] linkHeld;
  logic [LINK_W-1:0] linkWr;
  logic              effWr;

  assign effWr      = wrEn && !clrSync && !wrData[B_SRST];
  assign softRstReq = wrEn && !clrSync && wrData[B_SRST];
  assign linkWr     = wrData[B_LINK_LO +: LINK_W];
  assign linkFire   = effWr && (linkWr != '0) && (linkWr != linkHeld);

  always_comb begin
    cmd           = '0;
    cmd.runWr     = effWr;
    cmd.runVal    = wrData[B_RUN];
    cmd.keepVal   = wrData[B_KEEP];
    cmd.saveWr    = effWr && wrData[B_SAVE];
    cmd.restoreWr = effWr && wrData[B_RESTORE];
  end

  always_ff @(posedge clk) begin
    if (!rstN || clrSync) begin
      idleThr      <= '0;
      nyetThr      <= NYET_RST;
      keepConn     <= 1'b0;
      l1Hib        <= 1'b0;
      pmEn         <= '0;
      linkHeld     <= '0;
      linkReqValid <= 1'b0;
      linkReqCode  <= '0;
    end else begin
      linkReqValid <= linkFire;
      if (linkFire) linkReqCode <= linkWr;
      if (effWr) begin
        idleThr  <= wrData[B_IDLE_LO +: IDLE_W];
        nyetThr  <= wrData[B_NYET_LO +: NYET_W];
        keepConn <= wrData[B_KEEP];
        l1Hib    <= wrData[B_L1HIB];
        pmEn     <= wrData[B_PMEN_LO +: PMEN_W];
        linkHeld <= linkWr;
      end else if (suspExit) begin
        linkHeld <= '0;
      end
    end
  end

  always_comb begin
    rdData                        = '0;
    rdData[B_RUN]                 = runBit;
    rdData[B_IDLE_LO +: IDLE_W]   = idleThr;
    rdData[B_NYET_LO +: NYET_W]   = nyetThr;
    rdData[B_KEEP]                = keepConn;
    rdData[B_L1HIB]               = l1Hib;
    rdData[B_PMEN_LO +: PMEN_W]   = pmEn;
  end
endmodule

// File: rtl/runctl_ctrl.sv
module runctl_ctrl
  import runctl_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  swCmd_t cmd,
  input  logic   softRstReq,
  input  logic   keepConn,
  input  logic   linkFire,
  input  logic   coreIdle,
  input  logic   discDone,
  input  logic   saveDone,
  input  logic   hostResumeReq,
  output logic   clrSync,
  output logic   runActive,
  output logic   halted,
  output logic   discReq,
  output logic   saveReq,
  output logic   saveBusy,
  output logic   restoreReq,
  output logic   resumePending,
  output logic   autoResume
);
  runSt_t state;
  logic   discSeen;
  logic   keepAtStop;
  logic   stopDone;

  assign runActive = (state == ST_RUN);
  assign stopDone  = coreIdle && (keepAtStop || discSeen || discDone);

  always_ff @(posedge clk) begin
    if (!rstN || clrSync) begin
      state         <= ST_HALT;
      halted        <= 1'b1;
      discSeen      <= 1'b0;
      keepAtStop    <= 1'b0;
      discReq       <= 1'b0;
      saveReq       <= 1'b0;
      saveBusy      <= 1'b0;
      restoreReq    <= 1'b0;
      resumePending <= 1'b0;
      autoResume    <= 1'b0;
      clrSync       <= 1'b0;
    end else begin
      clrSync    <= softRstReq;
      discReq    <= 1'b0;
      saveReq    <= 1'b0;
      autoResume <= 1'b0;
      restoreReq <= cmd.restoreWr;

      if (cmd.runWr && cmd.runVal) begin
        state    <= ST_RUN;
        halted   <= 1'b0;
        discSeen <= 1'b0;
      end else begin
        case (state)
          ST_RUN: if (cmd.runWr) begin
            state      <= ST_STOP;
            keepAtStop <= cmd.keepVal;
            discReq    <= !cmd.keepVal;
            discSeen   <= 1'b0;
          end
          ST_STOP: begin
            if (discDone) discSeen <= 1'b1;
            if (stopDone) begin
              state  <= ST_HALT;
              halted <= 1'b1;
            end
          end
          default: ;
        endcase
      end

      if (cmd.saveWr && !saveBusy) begin
        saveBusy <= 1'b1;
        saveReq  <= 1'b1;
      end else if (saveDone) begin
        saveBusy <= 1'b0;
      end

      if (hostResumeReq) begin
        if (keepConn) resumePending <= 1'b1;
        else          autoResume    <= 1'b1;
      end else if (linkFire) begin
        resumePending <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/usb_run_ctrl.sv
module usb_run_ctrl
  import runctl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  input  logic              coreIdle,
  input  logic              discDone,
  input  logic              saveDone,
  input  logic              suspExit,
  input  logic              hostResumeReq,
  output logic              runActive,
  output logic              halted,
  output logic              discReq,
  output logic              saveReq,
  output logic              saveBusy,
  output logic              restoreReq,
  output logic              linkReqValid,
  output logic [3:0]        linkReqCode,
  output logic              resumePending,
  output logic              autoResume,
  output logic              coreRst
);
  swCmd_t cmd;
  logic   softRstReq;
  logic   keepConn;
  logic   linkFire;
  logic   clrSync;

  assign coreRst = clrSync;

  runctl_datapath dp_i (
    .clk(clk), .rstN(rstN), .clrSync(clrSync),
    .wrEn(wrEn), .wrData(wrData), .suspExit(suspExit),
    .runBit(runActive), .cmd(cmd), .softRstReq(softRstReq),
    .keepConn(keepConn), .linkFire(linkFire),
    .linkReqValid(linkReqValid), .linkReqCode(linkReqCode),
    .rdData(rdData)
  );

  runctl_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .softRstReq(softRstReq),
    .keepConn(keepConn), .linkFire(linkFire),
    .coreIdle(coreIdle), .discDone(discDone), .saveDone(saveDone),
    .hostResumeReq(hostResumeReq), .clrSync(clrSync),
    .runActive(runActive), .halted(halted), .discReq(discReq),
    .saveReq(saveReq), .saveBusy(saveBusy), .restoreReq(restoreReq),
    .resumePending(resumePending), .autoResume(autoResume)
  );
endmodule

// File: rtl/usb_run_ctrl_chk.sv
module usb_run_ctrl_chk (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [31:0] wrData,
  input logic        coreIdle,
  input logic        saveDone,
  input logic        runActive,
  input logic        halted,
  input logic        discReq,
  input logic        saveBusy,
  input logic        linkReqValid,
  input logic [3:0]  linkReqCode,
  input logic        coreRst
);
  AST_SAVE_BUSY_SET: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[16] && !wrData[30] && !saveBusy && !coreRst) |=> saveBusy); // R4

  AST_SAVE_BUSY_CLR: assert property (@(posedge clk) disable iff (!rstN)
    (saveBusy && saveDone) |=> !saveBusy); // R4

  AST_HALT_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(halted) && !$past(coreRst)) |-> $past(coreIdle)); // R2

  AST_KEEP_NO_DISC: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrData[31] && wrData[19] && !wrData[30] && runActive && !coreRst) |=> !discReq); // R3

  AST_LINK_CODE_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    linkReqValid |-> (linkReqCode != 4'd0)); // R6

  AST_SOFTRST_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    coreRst |=> (!coreRst && halted && !saveBusy)); // R9
endmodule

bind usb_run_ctrl usb_run_ctrl_chk chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
  .coreIdle(coreIdle), .saveDone(saveDone), .runActive(runActive),
  .halted(halted), .discReq(discReq), .saveBusy(saveBusy),
  .linkReqValid(linkReqValid), .linkReqCode(linkReqCode), .coreRst(coreRst)
);

// File: tb/usb_run_ctrl_tb_top.sv
module usb_run_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        coreIdle = 1'b0, discDone = 1'b0, saveDone = 1'b0;
  logic        suspExit = 1'b0, hostResumeReq = 1'b0;
  logic        runActive, halted, discReq, saveReq, saveBusy, restoreReq;
  logic        linkReqValid, resumePending, autoResume, coreRst;
  logic [3:0]  linkReqCode;

  int nChecks = 0;
  int nFails  = 0;
  bit doneFlag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_run_ctrl dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .coreIdle(coreIdle), .discDone(discDone), .saveDone(saveDone),
    .suspExit(suspExit), .hostResumeReq(hostResumeReq),
    .runActive(runActive), .halted(halted), .discReq(discReq),
    .saveReq(saveReq), .saveBusy(saveBusy), .restoreReq(restoreReq),
    .linkReqValid(linkReqValid), .linkReqCode(linkReqCode),
    .resumePending(resumePending), .autoResume(autoResume), .coreRst(coreRst)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic doWrite(input logic [31:0] d);
    wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic pulseDisc();
    discDone = 1'b1; @(negedge clk); discDone = 1'b0;
  endtask

  task automatic pulseSusp();
    suspExit = 1'b1; @(negedge clk); suspExit = 1'b0;
  endtask

  task automatic pulseResume();
    hostResumeReq = 1'b1; @(negedge clk); hostResumeReq = 1'b0;
  endtask

  task automatic testReset();
    chk("R8", "rdData", rdData, 32'h00F0_0000);
    chk("R8", "halted", halted, 1);
    chk("R8", "saveBusy", saveBusy, 0);
  endtask

  task automatic testRunFields();
    doWrite(32'h953C_1E00);
    chk("R1", "runActive", runActive, 1);
    chk("R1", "halted", halted, 0);
    chk("R11", "rdData", rdData, 32'h953C_1E00);
    doWrite(32'h0000_0000);
    chk("R2", "discReq", discReq, 1);
    coreIdle = 1'b1; step(1);
    chk("R2", "discReq one cycle", discReq, 0);
    chk("R2", "halted before discDone", halted, 0);
    pulseDisc();
    chk("R2", "halted after both", halted, 1);
    coreIdle = 1'b0;
  endtask

  task automatic testStopOrder();
    doWrite(32'h8000_0000);
    doWrite(32'h0000_0000);
    pulseDisc();
    chk("R2", "halted waits idle", halted, 0);
    coreIdle = 1'b1; step(1);
    chk("R2", "halted after idle", halted, 1);
    coreIdle = 1'b0;
  endtask

  task automatic testKeep();
    doWrite(32'h8008_0000);
    doWrite(32'h0008_0000);
    chk("R3", "no discReq", discReq, 0);
    step(1);
    chk("R3", "halted waits idle", halted, 0);
    coreIdle = 1'b1; step(1);
    chk("R3", "halted on idle", halted, 1);
    coreIdle = 1'b0;
  endtask

  task automatic testSave();
    doWrite(32'h0001_0000);
    chk("R4", "saveBusy set", saveBusy, 1);
    chk("R4", "saveReq", saveReq, 1);
    chk("R5", "save bit reads 0", rdData[16], 0);
    doWrite(32'h0001_0000);
    chk("R4", "busy write ignored", saveReq, 0);
    saveDone = 1'b1; wrEn = 1'b1; wrData = 32'h0001_0000;
    @(negedge clk);
    saveDone = 1'b0; wrEn = 1'b0; wrData = '0;
    chk("R4", "collision busy clear", saveBusy, 0);
    chk("R4", "collision no saveReq", saveReq, 0);
    doWrite(32'h0001_0000);
    chk("R4", "new save accepted", saveReq, 1);
    saveDone = 1'b1; @(negedge clk); saveDone = 1'b0;
    chk("R4", "busy cleared", saveBusy, 0);
  endtask

  task automatic testRestore();
    doWrite(32'h0002_0000);
    chk("R5", "restoreReq", restoreReq, 1);
    chk("R5", "restore bit reads 0", rdData[17], 0);
    step(1);
    chk("R5", "restoreReq one cycle", restoreReq, 0);
  endtask

  task automatic testLink();
    doWrite(32'h0000_0060);
    chk("R6", "first valid", linkReqValid, 1);
    chk("R6", "code", linkReqCode, 4'd3);
    chk("R6", "field reads 0", rdData[8:5], 0);
    doWrite(32'h0000_0060);
    chk("R6", "repeat suppressed", linkReqValid, 0);
    doWrite(32'h0000_0000);
    chk("R6", "zero no request", linkReqValid, 0);
    doWrite(32'h0000_0060);
    chk("R6", "rearmed", linkReqValid, 1);
    pulseSusp();
    doWrite(32'h0000_0060);
    chk("R7", "after suspExit", linkReqValid, 1);
    chk("R7", "code", linkReqCode, 4'd3);
  endtask

  task automatic testResume();
    doWrite(32'h0008_0000);
    pulseResume();
    chk("R10", "pending set", resumePending, 1);
    chk("R10", "no autoResume", autoResume, 0);
    doWrite(32'h0008_0040);
    chk("R10", "pending cleared by link", resumePending, 0);
    doWrite(32'h0000_0000);
    pulseResume();
    chk("R10", "autoResume", autoResume, 1);
    chk("R10", "no pending", resumePending, 0);
  endtask

  task automatic testSoftRst();
    doWrite(32'h953C_1E00);
    doWrite(32'h0001_0000);
    doWrite(32'h4001_0000);
    chk("R9", "coreRst", coreRst, 1);
    chk("R9", "no save from srst write", saveReq, 0);
    chk("R8", "bit30 reads 0", rdData[30], 0);
    step(1);
    chk("R9", "coreRst one cycle", coreRst, 0);
    chk("R9", "rdData default", rdData, 32'h00F0_0000);
    chk("R9", "halted", halted, 1);
    chk("R9", "saveBusy", saveBusy, 0);
    chk("R9", "runActive", runActive, 0);
  endtask

  initial begin
    step(3);
    rstN = 1'b1;
    step(1);
    testReset();
    testRunFields();
    testStopOrder();
    testKeep();
    testSave();
    testRestore();
    testLink();
    testResume();
    testSoftRst();
    doneFlag = 1;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (doneFlag) break;
    end
    if (!doneFlag) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual running expected finished");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule